// File: doc/BRIEF.md
# Fault Blink-Code Status LED

This block drives a single board status LED. While the board is healthy the LED is lit without a break. When a fault is present, the LED repeats a fixed frame of eight slots. It lights the first N slots with one short blink each and leaves the other slots dark. N is the code of the fault being reported, so the number of blinks per frame tells an operator which fault class is active.

There are seven codes. Code 1 is a module power-good failure. Code 2 is reserved. Code 3 is a mezzanine power error. Code 4 is an overcurrent on the auxiliary 5 V supply. Code 5 is a USB power error. Code 6 is a fault on either optical module. Code 7 is an SFP transmit fault or loss of signal.

Each code has its own input flag. When several flags are high, the lowest code wins. The code is captured when a frame starts and is kept until that frame ends. A parameterized prescaler sets the slot length in clock cycles. Detecting the faults and choosing the clock are left to the surrounding logic.

Top module: `fault_blink_led`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, led_o is 1 and no frame is running.
- R2: While no unmasked fault flag is high and no frame is running, led_o stays 1.
- R3: A frame is 8 slots of SLOT_CYC cycles each, so it lasts 8*SLOT_CYC cycles. For code N, slots 0 to N-1 are blink slots.
- R4: Within a blink slot, led_o is 1 for the first SLOT_CYC/2 cycles and 0 for the rest of the slot.
- R5: Slots N to 7 of a frame are dark (led_o = 0). Every valid code is at most 7, so slot 7 is always dark.
- R6: Bit k of fault_i (k = 0..6) raises code k+1. When several bits are high, the lowest code is reported.
- R7: Bit 1 of fault_i (code 2, reserved) has no effect. With only that bit high, led_o stays 1.
- R8: The code is latched when a frame starts. Changes on fault_i during the frame do not change the blink pattern until the frame ends.
- R9: When no frame is running, a frame starts on the first clock edge at which an unmasked fault is present. Slot 0 then begins on the next cycle.
- R10: At the end of a frame, if an unmasked fault is present, a new frame starts at once with a freshly latched code. Otherwise the LED returns to steady on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | NUM_CODES | One fault flag per code; bit k is code k+1 |
| led_o | output | 1 | Status LED drive, 1 = lit |

## Verification
The hardest situation to create from the ports is a fault set that changes close to a frame boundary. This is where a latched code must either hold or be replaced, and where the block either returns to steady on or restarts a frame at once. The directed stimulus reaches these cases in three ways:
- It switches faults in the middle of a frame.
- It drops faults before the frame ends.
- It holds faults across several frames.

Random fault sets, with sparse bits and held for varying lengths, then land edges on arbitrary slot and cycle positions. A cycle-accurate reference model in the bench compares led_o on every cycle.

// File: rtl/fault_blink_pkg.sv
package fault_blink_pkg;
  localparam int unsigned SLOTS_PER_FRAME = 8;
  localparam int unsigned SLOT_W          = $clog2(SLOTS_PER_FRAME);
  localparam int unsigned RESERVED_CODE   = 2;

  typedef logic [SLOT_W-1:0] code_t;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int unsigned SLOT_CYC = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic slot_end_o,
  output logic first_half_o
);
  localparam int unsigned CNT_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int unsigned HALF  = SLOT_CYC / 2;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign slot_end_o   = en_i && (cnt_q == LAST);
  assign first_half_o = (cnt_q < HALF_C);

  AST_CNT_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);  // R4
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);  // R9
endmodule

// File: rtl/blink_prio_enc.sv
module blink_prio_enc
  import fault_blink_pkg::*;
#(
  parameter int unsigned NUM_CODES = 7
) (
  input  logic [NUM_CODES-1:0] fault_i,
  output logic                 any_o,
  output code_t                code_o
);
  logic [NUM_CODES-1:0] valid;

  generate
    for (genvar k = 0; k < NUM_CODES; k++) begin : g_mask
      if (k + 1 == RESERVED_CODE) begin : g_res
        assign valid[k] = 1'b0;
      end else begin : g_use
        assign valid[k] = fault_i[k];
      end
    end
  endgenerate

  always_comb begin
    code_o = '0;
    for (int i = NUM_CODES - 1; i >= 0; i--) begin
      if (valid[i]) code_o = code_t'(i + 1);
    end
  end

  assign any_o = |valid;
endmodule

// File: rtl/blink_frame_seq.sv
module blink_frame_seq
  import fault_blink_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  any_i,
  input  code_t code_i,
  input  logic  slot_end_i,
  input  logic  first_half_i,
  output logic  active_o,
  output logic  led_o
);
  localparam slot_t LAST_SLOT = slot_t'(SLOTS_PER_FRAME - 1);

  logic  active_q;
  slot_t slot_q;
  code_t code_q;
  logic  frame_end;

  assign frame_end = active_q && slot_end_i && (slot_q == LAST_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      code_q   <= '0;
    end else if (!active_q) begin
      if (any_i) begin
        active_q <= 1'b1;
        slot_q   <= '0;
        code_q   <= code_i;
      end
    end else if (slot_end_i) begin
      if (slot_q == LAST_SLOT) begin
        slot_q <= '0;
        if (any_i) code_q   <= code_i;
        else       active_q <= 1'b0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign led_o    = !active_q || ((slot_q < code_q) && first_half_i);

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !frame_end |=> $stable(code_q));  // R8
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && slot_end_i && slot_q != LAST_SLOT |=> slot_q == $past(slot_q) + 1'b1);  // R3
  AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> code_q != code_t'(RESERVED_CODE));  // R7
  AST_CODE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> code_q != '0);  // R6
  AST_LAST_SLOT_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && slot_q == LAST_SLOT |-> !led_o);  // R5
  AST_BACK_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && !any_i |=> !active_q);  // R10
  AST_START_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && any_i |=> active_q && slot_q == '0);  // R9
endmodule

// File: rtl/fault_blink_led.sv
module fault_blink_led
  import fault_blink_pkg::*;
#(
  parameter int unsigned NUM_CODES = 7,
  parameter int unsigned SLOT_CYC  = 12_500_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CODES-1:0] fault_i,
  output logic                 led_o
);
  logic  any_fault;
  code_t low_code;
  logic  active;
  logic  slot_end;
  logic  first_half;

  blink_prio_enc #(.NUM_CODES(NUM_CODES)) u_enc (
    .fault_i (fault_i),
    .any_o   (any_fault),
    .code_o  (low_code)
  );

  blink_prescaler #(.SLOT_CYC(SLOT_CYC)) u_pre (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (active),
    .slot_end_o   (slot_end),
    .first_half_o (first_half)
  );

  blink_frame_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .any_i        (any_fault),
    .code_i       (low_code),
    .slot_end_i   (slot_end),
    .first_half_i (first_half),
    .active_o     (active),
    .led_o        (led_o)
  );

  AST_PARAMS: assert final (NUM_CODES < SLOTS_PER_FRAME && SLOT_CYC >= 2);  // R3
  AST_IDLE_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> led_o);  // R2
endmodule

// File: tb/sim_fault_blink_led.sv
module sim_fault_blink_led;
  localparam int NC   = 7;
  localparam int SC   = 8;
  localparam int HALF = SC / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] fault = '0;
  logic          led;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  fault_blink_led #(.NUM_CODES(NC), .SLOT_CYC(SC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .led_o(led)
  );

  always #4 clk = ~clk;

  // reference model
  bit m_act;
  int m_slot, m_cyc, m_code;

  function automatic int lowest(logic [NC-1:0] f);
    for (int i = 0; i < NC; i++)
      if (f[i] && i != 1) return i + 1;
    return 0;
  endfunction

  function automatic bit exp_led();
    if (!m_act) return 1'b1;
    return (m_slot < m_code) && (m_cyc < HALF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_slot <= 0; m_cyc <= 0; m_code <= 0;
    end else if (!m_act) begin
      if (lowest(fault) != 0) begin
        m_act <= 1; m_slot <= 0; m_cyc <= 0; m_code <= lowest(fault);
      end
    end else if (m_cyc == SC - 1) begin
      m_cyc <= 0;
      if (m_slot == 7) begin
        m_slot <= 0;
        if (lowest(fault) != 0) m_code <= lowest(fault);
        else m_act <= 0;
      end else m_slot <= m_slot + 1;
    end else m_cyc <= m_cyc + 1;
  end

  task automatic chk(string req, bit act, bit ex);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s: led_o actual=%0b expected=%0b (slot %0d cyc %0d code %0d)",
               req, act, ex, m_slot, m_cyc, m_code);
    end
  endtask

  // per-cycle compare at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      string r;
      if (!m_act)                 r = "R2";
      else if (m_slot >= m_code)  r = "R5";
      else if (m_cyc < HALF)      r = "R3";
      else                        r = "R4";
      chk({tag, " ", r}, led, exp_led());
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1", led, 1'b1);
    wait_cyc(3);
    chk("R1", led, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1"; wait_cyc(1);
    tag = "R2"; wait_cyc(20);
    // R7: reserved bit alone has no effect
    tag = "R7"; fault = 7'b0000010; wait_cyc(100);
    // R9, R3: code 3 starts on first edge
    tag = "R9"; fault = 7'b0000100; wait_cyc(2);
    tag = "R3"; wait_cyc(8 * SC * 2);
    // R6: codes 3 and 6 together -> 3; add code 2 too
    tag = "R6"; fault = 7'b0100110; wait_cyc(8 * SC);
    // R8: change mid-frame to code 1
    tag = "R8"; wait_cyc(3 * SC + 1); fault = 7'b0000001; wait_cyc(3 * SC);
    fault = 7'b1000000; wait_cyc(8 * SC);
    // R10: drop fault before frame end -> steady on
    tag = "R10"; fault = '0; wait_cyc(8 * SC + 10);
    // code 7 and code 1 extremes
    tag = "R5"; fault = 7'b1000000; wait_cyc(8 * SC * 2);
    tag = "R6"; fault = 7'b1111111; wait_cyc(8 * SC * 2);
    tag = "R10"; fault = '0; wait_cyc(8 * SC);
    // reset in mid-frame
    tag = "R1"; fault = 7'b0010000; wait_cyc(13);
    rst_n = 1'b0; #1; chk("R1", led, 1'b1);
    @(negedge clk) rst_n = 1'b1; fault = '0; wait_cyc(5);
    // random
    tag = "RND";
    for (int n = 0; n < 400; n++) begin
      logic [NC-1:0] f;
      f = NC'($urandom) & NC'($urandom) & NC'($urandom);
      if ($urandom_range(0, 3) == 0) f = '0;
      fault = f;
      wait_cyc($urandom_range(1, 3 * 8 * SC));
    end
    fault = '0;
    wait_cyc(8 * SC + 4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule